// File: doc/BRIEF.md
# Interrupt destination resolver

This block sits between the register port of an interrupt command register and the fabric that carries interrupts to a set of local interrupt controllers (targets, `N_TGT` of them, eight by default). Software writes a high command word to set the destination byte. It then writes a low command word, which starts a send. The block decodes the command fields and applies the destination shorthand. It resolves physical or logical addressing against each target's ID, logical destination and format model. The result is a per-target delivery mask, together with the delivery mode, vector and trigger. These are offered on a valid/ready handshake.

Lowest-priority delivery reduces the mask to its lowest-numbered target. An INIT de-assert command delivers nothing. It raises a one-cycle reload pulse with a mask, telling the selected targets to reload their arbitration ID from their own ID.

The control is a three-state machine:
- IDLE waits for a low-word write and takes the START transition to RESOLVE.
- RESOLVE computes and registers the result. It takes the RELOAD transition back to IDLE for an INIT de-assert, and the ISSUE transition to OFFER otherwise.
- OFFER holds the result until the consumer accepts it, then takes the ACCEPT transition back to IDLE.

Top module: `irq_dest_resolver`

## Requirements
- R1: The low word decodes as vector = bits [7:0], delivery mode = bits [10:8], logical addressing = bit 11, level = bit 14, trigger = bit 15 and shorthand = bits [19:18]. The offered vector, mode and trigger equal those fields.
- R2: A low-word write (`wr_en`=1, `wr_hi_sel`=0) accepted while `cmd_ready`=1 starts a send, and the result appears two clock edges later. A high-word write only stores bits [31:24] as the destination byte and produces no output. The destination byte is captured when the send starts.
- R3: Shorthand 1 selects only the target numbered `sender_idx`.
- R4: Shorthand 2 selects every target. Shorthand 3 selects every target except `sender_idx`.
- R5: With shorthand 0 and physical addressing, destination 0xFF selects every target. Any other destination selects the lowest-numbered target whose ID equals it, or no target if none does.
- R6: With shorthand 0 and logical addressing, a target with format 0xF matches when the destination AND its logical destination is nonzero.
- R7: With shorthand 0 and logical addressing, a target with format 0x0 matches when the upper nibbles are equal and the lower nibbles share a set bit. A target with any other format never matches logically.
- R8: When the delivery mode is 1 (lowest priority), only the lowest-numbered set bit of the mask is offered.
- R9: When the delivery mode is 5 with level 0 and trigger 1, nothing is offered. `reload_pulse` is high for exactly one cycle, with `reload_mask` holding the selected mask.
- R10: While `out_valid`=1 and `out_ready`=0, all offered fields hold steady. `cmd_ready` stays low from the start of a send until the offer is accepted, and a low-word write made while `cmd_ready`=0 is ignored.
- R11: A send whose mask is empty is still offered, with every mask bit zero, and completes the handshake.
- R12: After reset `cmd_ready`=1, `out_valid`=0, `reload_pulse`=0 and the stored destination byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command word write strobe |
| wr_hi_sel | input | 1 | 1 selects the high word, 0 the low word |
| wr_data | input | 32 | Command word data |
| cmd_ready | output | 1 | A low-word write will be accepted |
| sender_idx | input | IDX_W | Index of the sending target, captured at send start |
| tgt_id | input | N_TGT*8 | ID of each target, target i in bits [8i+7:8i] |
| tgt_ldest | input | N_TGT*8 | Logical destination of each target |
| tgt_fmt | input | N_TGT*4 | Format model of each target |
| out_valid | output | 1 | Offered delivery is valid |
| out_ready | input | 1 | Consumer accepts the offer |
| out_mask | output | N_TGT | Delivery mask, bit i is target i |
| out_mode | output | 3 | Delivery mode |
| out_vector | output | 8 | Vector |
| out_trig | output | 1 | Trigger mode |
| reload_pulse | output | 1 | One-cycle arbitration-ID reload request |
| reload_mask | output | N_TGT | Targets asked to reload |

## Verification
The bench sweeps all 256 destination bytes in physical mode, logical mode and lowest-priority mode against a target table that contains a duplicated ID, flat and cluster targets, and one target with an unsupported format. A design that kept every duplicate-ID target, confused the cluster nibble rule with the flat rule, or let the unsupported format match would give the wrong mask for specific bytes. Every shorthand is tried with every sender index, which exposes an inverted or off-by-one self bit. It also covers INIT with both level values, a send made while an offer is stalled, and an empty mask. A design that offered the INIT de-assert, changed the stalled outputs, accepted the blocked write, or dropped an empty send would show it at the ports.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESOLVE = 2'd1,
        ST_OFFER   = 2'd2
    } rs_state_e;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    localparam logic [2:0] DM_LOWEST   = 3'd1;
    localparam logic [2:0] DM_INIT     = 3'd5;
    localparam logic [3:0] FMT_FLAT    = 4'hF;
    localparam logic [3:0] FMT_CLUSTER = 4'h0;
    localparam logic [7:0] DEST_BCAST  = 8'hFF;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] mode;
        logic       logical;
        logic       level;
        logic       trig;
        shorthand_e sh;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [19:0] w);
        cmd_t c;
        c.vector  = w[7:0];
        c.mode    = w[10:8];
        c.logical = w[11];
        c.level   = w[14];
        c.trig    = w[15];
        c.sh      = shorthand_e'(w[19:18]);
        return c;
    endfunction

endpackage

// File: rtl/irq_tgt_match.sv
module irq_tgt_match
    import irq_dest_pkg::*;
(
    input  logic [7:0] dest,
    input  logic [7:0] id,
    input  logic [7:0] ldest,
    input  logic [3:0] fmt,
    output logic       phys_hit,
    output logic       log_hit
);
    logic flat_hit;
    logic clus_hit;

    always_comb begin
        phys_hit = (id == dest);
        flat_hit = |(dest & ldest);
        clus_hit = (dest[7:4] == ldest[7:4]) && |(dest[3:0] & ldest[3:0]);
        unique case (fmt)
            FMT_FLAT:    log_hit = flat_hit;
            FMT_CLUSTER: log_hit = clus_hit;
            default:     log_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_lowest_bit.sv
module irq_lowest_bit #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec_in,
    output logic [W-1:0] vec_out
);
    assign vec_out = vec_in & (~vec_in + W'(1));
endmodule

// File: rtl/irq_dest_select.sv
module irq_dest_select
    import irq_dest_pkg::*;
#(
    parameter int N_TGT = 8,
    parameter int IDX_W = $clog2(N_TGT)
) (
    input  shorthand_e         sh,
    input  logic               logical,
    input  logic [7:0]         dest,
    input  logic [IDX_W-1:0]   sender,
    input  logic [N_TGT*8-1:0] tgt_id,
    input  logic [N_TGT*8-1:0] tgt_ldest,
    input  logic [N_TGT*4-1:0] tgt_fmt,
    output logic [N_TGT-1:0]   mask
);
    logic [N_TGT-1:0] phys_hit;
    logic [N_TGT-1:0] log_hit;
    logic [N_TGT-1:0] phys_first;
    logic [N_TGT-1:0] self_bit;

    for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
        irq_tgt_match u_match (
            .dest     (dest),
            .id       (tgt_id[i*8 +: 8]),
            .ldest    (tgt_ldest[i*8 +: 8]),
            .fmt      (tgt_fmt[i*4 +: 4]),
            .phys_hit (phys_hit[i]),
            .log_hit  (log_hit[i])
        );
        assign self_bit[i] = (sender == IDX_W'(i));
    end

    irq_lowest_bit #(.W(N_TGT)) u_first (
        .vec_in  (phys_hit),
        .vec_out (phys_first)
    );

    always_comb begin
        unique case (sh)
            SH_SELF:   mask = self_bit;
            SH_ALL:    mask = '1;
            SH_OTHERS: mask = ~self_bit;
            default: begin
                if (logical)                 mask = log_hit;
                else if (dest == DEST_BCAST) mask = '1;
                else                         mask = phys_first;
            end
        endcase
    end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
    import irq_dest_pkg::*;
#(
    parameter int N_TGT = 8,
    parameter int IDX_W = $clog2(N_TGT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_hi_sel,
    input  logic [31:0]        wr_data,
    output logic               cmd_ready,
    input  logic [IDX_W-1:0]   sender_idx,
    input  logic [N_TGT*8-1:0] tgt_id,
    input  logic [N_TGT*8-1:0] tgt_ldest,
    input  logic [N_TGT*4-1:0] tgt_fmt,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [N_TGT-1:0]   out_mask,
    output logic [2:0]         out_mode,
    output logic [7:0]         out_vector,
    output logic               out_trig,
    output logic               reload_pulse,
    output logic [N_TGT-1:0]   reload_mask
);
    rs_state_e        state_q, state_d;
    logic [7:0]       hi_dest_q;
    logic [7:0]       dest_q;
    logic [IDX_W-1:0] sender_q;
    cmd_t             cmd_q;
    logic [N_TGT-1:0] sel_mask;
    logic [N_TGT-1:0] low_mask;
    logic             lo_write;
    logic             init_deassert;
    logic             unused_bits;

    assign unused_bits   = ^{wr_data[23:20], wr_data[17:16], wr_data[13:12]};
    assign lo_write      = wr_en && !wr_hi_sel && (state_q == ST_IDLE);
    assign init_deassert = (cmd_q.mode == DM_INIT) && !cmd_q.level && cmd_q.trig;
    assign cmd_ready     = (state_q == ST_IDLE);

    irq_dest_select #(.N_TGT(N_TGT), .IDX_W(IDX_W)) u_sel (
        .sh        (cmd_q.sh),
        .logical   (cmd_q.logical),
        .dest      (dest_q),
        .sender    (sender_q),
        .tgt_id    (tgt_id),
        .tgt_ldest (tgt_ldest),
        .tgt_fmt   (tgt_fmt),
        .mask      (sel_mask)
    );

    irq_lowest_bit #(.W(N_TGT)) u_lowpick (
        .vec_in  (sel_mask),
        .vec_out (low_mask)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: START, RELOAD, ISSUE, ACCEPT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (lo_write) state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = init_deassert ? ST_IDLE : ST_OFFER;
            ST_OFFER:   if (out_ready) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // command capture and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_dest_q    <= '0;
            dest_q       <= '0;
            sender_q     <= '0;
            cmd_q        <= decode_cmd('0);
            out_valid    <= 1'b0;
            out_mask     <= '0;
            out_mode     <= '0;
            out_vector   <= '0;
            out_trig     <= 1'b0;
            reload_pulse <= 1'b0;
            reload_mask  <= '0;
        end else begin
            reload_pulse <= 1'b0;
            if (wr_en && wr_hi_sel) hi_dest_q <= wr_data[31:24];
            unique case (state_q)
                ST_IDLE: begin
                    if (lo_write) begin
                        cmd_q    <= decode_cmd(wr_data[19:0]);
                        dest_q   <= hi_dest_q;
                        sender_q <= sender_idx;
                    end
                end
                ST_RESOLVE: begin
                    if (init_deassert) begin
                        reload_pulse <= 1'b1;
                        reload_mask  <= sel_mask;
                    end else begin
                        out_valid  <= 1'b1;
                        out_mask   <= (cmd_q.mode == DM_LOWEST) ? low_mask : sel_mask;
                        out_mode   <= cmd_q.mode;
                        out_vector <= cmd_q.vector;
                        out_trig   <= cmd_q.trig;
                    end
                end
                ST_OFFER: begin
                    if (out_ready) out_valid <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
    parameter int N_TGT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_hi_sel,
    input logic             cmd_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [N_TGT-1:0] out_mask,
    input logic [2:0]       out_mode,
    input logic [7:0]       out_vector,
    input logic             out_trig,
    input logic             reload_pulse
);
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_mask) && $stable(out_mode)
                                    && $stable(out_vector) && $stable(out_trig));

    p_busy_while_offer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cmd_ready);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready && wr_en && !wr_hi_sel |=> !cmd_ready && !out_valid);

    p_hi_store_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready && wr_en && wr_hi_sel |=> cmd_ready && !out_valid && !reload_pulse);

    p_lowest_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_mode == 3'd1 |-> $onehot0(out_mask));

    p_reload_no_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |-> !out_valid);

    p_reload_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reload_pulse |=> !reload_pulse && cmd_ready);
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(.N_TGT(N_TGT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_hi_sel    (wr_hi_sel),
    .cmd_ready    (cmd_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_mask     (out_mask),
    .out_mode     (out_mode),
    .out_vector   (out_vector),
    .out_trig     (out_trig),
    .reload_pulse (reload_pulse)
);

// File: tb/sim_irq_dest_resolver.sv
`timescale 1ns/1ps
module sim_irq_dest_resolver;
    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_hi_sel = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          cmd_ready;
    logic [IW-1:0] sender_idx = '0;
    logic [N*8-1:0] tgt_id;
    logic [N*8-1:0] tgt_ldest;
    logic [N*4-1:0] tgt_fmt;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [N-1:0]  out_mask;
    logic [2:0]    out_mode;
    logic [7:0]    out_vector;
    logic          out_trig;
    logic          reload_pulse;
    logic [N-1:0]  reload_mask;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_dest_resolver #(.N_TGT(N)) u0 (.*);

    // target table: id 7 duplicated at 1 and 6, targets 0-3 flat, 4-6 cluster, 7 unsupported
    function automatic logic [7:0] t_id(int i);
        return (i == 6) ? 8'h07 : 8'(5 + 2 * i);
    endfunction
    function automatic logic [3:0] t_fmt(int i);
        return (i < 4) ? 4'hF : (i < 7) ? 4'h0 : 4'h5;
    endfunction
    function automatic logic [7:0] t_ldest(int i);
        case (i)
            0: return 8'h81;
            1: return 8'h02;
            2: return 8'h04;
            3: return 8'h08;
            4: return 8'h21;
            5: return 8'h22;
            6: return 8'h33;
            default: return 8'hFF;
        endcase
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            tgt_id[i*8 +: 8]    = t_id(i);
            tgt_ldest[i*8 +: 8] = t_ldest(i);
            tgt_fmt[i*4 +: 4]   = t_fmt(i);
        end
    end

    function automatic logic [N-1:0] exp_mask(int sh, bit logical, logic [7:0] dest, int snd);
        logic [N-1:0] m = '0;
        case (sh)
            1: m[snd] = 1'b1;
            2: m = '1;
            3: begin m = '1; m[snd] = 1'b0; end
            default: begin
                if (!logical) begin
                    if (dest == 8'hFF) m = '1;
                    else for (int i = N - 1; i >= 0; i--) if (t_id(i) == dest) m = N'(1) << i;
                end else begin
                    for (int i = 0; i < N; i++) begin
                        logic [7:0] ld = t_ldest(i);
                        if (t_fmt(i) == 4'hF) m[i] = (dest & ld) != 0;
                        else if (t_fmt(i) == 4'h0)
                            m[i] = (dest[7:4] == ld[7:4]) && ((dest[3:0] & ld[3:0]) != 0);
                    end
                end
            end
        endcase
        return m;
    endfunction

    function automatic logic [N-1:0] lowest(logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return N'(1) << i;
        return '0;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_lo(logic [7:0] vec, int mode, bit logical,
                                          bit level, bit trig, int sh);
        return {12'h0, 2'(sh), 2'b00, trig, level, 2'b00, logical, 3'(mode), vec};
    endfunction

    // called at a negedge; returns at a negedge
    task automatic send(string tag, logic [7:0] dest, logic [31:0] lo, int snd,
                        bit exp_offer, logic [N-1:0] em);
        sender_idx = IW'(snd);
        wr_en = 1'b1; wr_hi_sel = 1'b1; wr_data = {dest, 24'h0};
        @(negedge clk);
        wr_hi_sel = 1'b0; wr_data = lo;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; sender_idx = '0;
        @(negedge clk);
        if (exp_offer) begin
            check(tag, {out_valid, reload_pulse, out_mask, out_mode, out_vector, out_trig},
                  {1'b1, 1'b0, em, lo[10:8], lo[7:0], lo[15]});
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            check({tag, " accept"}, {out_valid, cmd_ready}, {1'b0, 1'b1});
        end else begin
            check(tag, {out_valid, reload_pulse, reload_mask}, {1'b0, 1'b1, em});
            @(negedge clk);
            check({tag, " pulse end"}, {out_valid, reload_pulse, cmd_ready}, {1'b0, 1'b0, 1'b1});
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 reset", {cmd_ready, out_valid, reload_pulse}, {1'b1, 1'b0, 1'b0});
        // R12: stored destination byte is zero -> physical send to dest 0 (empty)
        wr_en = 1'b1; wr_hi_sel = 1'b0; wr_data = mk_lo(8'h10, 0, 0, 0, 0, 0);
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        check("R12 dest zero", {out_valid, out_mask}, {1'b1, exp_mask(0, 0, 8'h00, 0)});
        out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;

        // R2: high-word write alone produces nothing
        wr_en = 1'b1; wr_hi_sel = 1'b1; wr_data = 32'hFF00_0000;
        @(negedge clk); wr_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 hi only", {out_valid, reload_pulse, cmd_ready}, {1'b0, 1'b0, 1'b1});

        // R5 / R11 physical sweep, R1 fields
        for (int d = 0; d < 256; d++)
            send("R5 R1 R11 physical", 8'(d), mk_lo(8'(d) ^ 8'h5A, 0, 0, 1, d % 2, 0), 0,
                 1, exp_mask(0, 0, 8'(d), 0));
        // R6 R7 logical sweep
        for (int d = 0; d < 256; d++)
            send("R6 R7 logical", 8'(d), mk_lo(8'(d), 2 + d % 2, 1, 0, 0, 0), 0,
                 1, exp_mask(0, 1, 8'(d), 0));
        // R8 lowest priority sweep (logical)
        for (int d = 0; d < 256; d++)
            send("R8 lowest", 8'(d), mk_lo(8'hC3, 1, 1, 1, 0, 0), 0,
                 1, lowest(exp_mask(0, 1, 8'(d), 0)));
        // R3 R4 shorthands with every sender; destination ignored
        for (int s = 0; s < N; s++)
            for (int sh = 1; sh < 4; sh++)
                send(sh == 1 ? "R3 self" : "R4 all/others", 8'h05, mk_lo(8'(s * 16 + sh), 0, 1, 0, 1, sh),
                     s, 1, exp_mask(sh, 1, 8'h05, s));
        // R8 lowest with shorthand others
        send("R8 lowest others", 8'h00, mk_lo(8'h21, 1, 0, 0, 0, 3), 0, 1, 8'h02);
        // R9 INIT de-assert: no offer, reload pulse
        send("R9 init deassert all", 8'h00, mk_lo(8'h00, 5, 0, 0, 1, 2), 0, 0, 8'hFF);
        send("R9 init deassert phys", 8'h07, mk_lo(8'h00, 5, 0, 0, 1, 0), 0, 0, 8'h02);
        // R9 INIT with level 1 is delivered normally
        send("R9 init assert", 8'h09, mk_lo(8'h00, 5, 0, 1, 1, 0), 0, 1, 8'h04);

        // R10 hold and blocked write
        wr_en = 1'b1; wr_hi_sel = 1'b0; wr_data = mk_lo(8'h33, 0, 0, 0, 1, 2);
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        check("R10 offer", {out_valid, out_mask, out_vector}, {1'b1, 8'hFF, 8'h33});
        wr_en = 1'b1; wr_data = mk_lo(8'h44, 0, 0, 0, 0, 1);
        @(negedge clk); wr_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R10 hold", {out_valid, cmd_ready, out_mask, out_vector, out_trig},
                  {1'b1, 1'b0, 8'hFF, 8'h33, 1'b1});
            @(negedge clk);
        end
        out_ready = 1'b1; @(negedge clk); out_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check("R10 blocked write ignored", {out_valid, reload_pulse, cmd_ready}, {1'b0, 1'b0, 1'b1});
            @(negedge clk);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule